// File: doc/BRIEF.md
# Reversible Circuit Neighbour Generator

This block holds two small banks of reversible gate words: a synthesis bank with the current candidate circuit and a neighbour bank with a perturbed copy of it. A search engine, such as a genetic or annealing loop, asks for one of three moves through a command strobe and an operation code. It can fill the synthesis bank with random gates. It can build a neighbour by swapping two randomly chosen gates. It can build a neighbour by exchanging the first control line and the target line of one random gate. Every random choice comes from an internal 16-bit linear feedback shift register. Each move stays within the active gate count given with the command.

Each gate is a 9-bit word of three 3-bit line indices plus a 2-bit gate type. The type codes are 0 for CNOT, 1 for Toffoli and 2 for Fredkin. Both banks can be read at any time through combinational read ports. The block pulses `done` once for each accepted command. Scoring a circuit is left to other logic.

Top module: `revgate_nbr_gen`

## Requirements
- R1: After reset both banks hold all-zero gate words and types, and `done` is low.
- R2: The random register resets to 16'hACE1. On every clock edge after reset it shifts left by one bit, and bit 0 takes the XOR of bits 15, 13, 12 and 10.
- R3: Operation 0 (fill) writes synthesis entries 0 to n-1, one per cycle. Entry k takes the random value present at the (k+1)th edge after the accepting edge. Its gate word is bits [8:0] of that value. Its type is bits [10:9], except that 3 becomes 1. Entries n and above keep their contents, and the neighbour bank is untouched.
- R4: Operations 1 and 2 first copy all 8 synthesis entries into the neighbour bank. They never change the synthesis bank.
- R5: Operation 1 (crossover) then writes synthesis entry b into neighbour position a, and entry a into position b, types included.
- R6: Operation 2 (mutation) then rewrites neighbour entry a as the synthesis entry with fields [8:6] and [2:0] exchanged. Field [5:3] and the type are kept.
- R7: Indices come from the random value present at the 9th edge after acceptance: a = bits [7:0] mod n and b = bits [15:8] mod n. If b equals a, b becomes (b+1) mod n.
- R8: When n is 0, or the operation code is 3, `done` is high in the cycle right after the accepting edge and both banks stay unchanged.
- R9: The effective gate count n is the requested count limited to 8.
- R10: `done` is high for one cycle per command. For fill it comes n cycles after the accepting edge, and for crossover or mutation 9 cycles after it, well within 29.
- R11: A command strobe that arrives while an operation is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 2 | 0 fill, 1 crossover, 2 mutation, 3 no operation |
| gate_count | input | 8 | Active gate count |
| done | output | 1 | One-cycle completion pulse |
| syn_raddr | input | 3 | Synthesis bank read index |
| syn_rgate | output | 9 | Synthesis gate word at `syn_raddr` |
| syn_rtype | output | 2 | Synthesis gate type at `syn_raddr` |
| nbr_raddr | input | 3 | Neighbour bank read index |
| nbr_rgate | output | 9 | Neighbour gate word at `nbr_raddr` |
| nbr_rtype | output | 2 | Neighbour gate type at `nbr_raddr` |

## Verification
A random register that drifts by even one step, or a step counter that is off by one, shows up in the first gate word read after the next fill. It also shows up as a `done` pulse one cycle early or late. A wrong index reduction or copy leaves a neighbour entry that differs from the model as soon as the bank is swept after the next crossover or mutation. Small counts of 1 and 2, and a count above 8, are used to expose the modulo and clamp paths.

// File: rtl/revgate_nbr_gen.sv
module revgate_nbr_gen #(
  parameter int GATES = 8,
  parameter int LINE_W = 3,
  parameter int TYPE_W = 2,
  parameter int CNT_W = 8,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [1:0]                 cmd_op,
  input  logic [CNT_W-1:0]           gate_count,
  output logic                       done,
  input  logic [$clog2(GATES)-1:0]   syn_raddr,
  output logic [3*LINE_W-1:0]        syn_rgate,
  output logic [TYPE_W-1:0]          syn_rtype,
  input  logic [$clog2(GATES)-1:0]   nbr_raddr,
  output logic [3*LINE_W-1:0]        nbr_rgate,
  output logic [TYPE_W-1:0]          nbr_rtype
);
  localparam int GW = 3 * LINE_W;
  localparam int AW = $clog2(GATES);
  localparam logic [CNT_W-1:0] ONE = 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GATES - 1);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_FILL = 2'd1, S_COPY = 2'd2, S_EDIT = 2'd3} st_t;

  st_t st;
  logic [1:0] op_q;
  logic [CNT_W-1:0] n_q, syn_ptr, nbr_ptr;
  logic [15:0] rnd;
  logic [GATES-1:0][GW-1:0] syn_g, nbr_g;
  logic [GATES-1:0][TYPE_W-1:0] syn_t, nbr_t;

  logic [CNT_W-1:0] n_in, n_div, idx_a, idx_b_raw, idx_b;
  logic [TYPE_W-1:0] rnd_type;
  logic [GW-1:0] mut_word;

  assign n_in = (gate_count > CNT_W'(GATES)) ? CNT_W'(GATES) : gate_count;
  assign n_div = (n_q == '0) ? ONE : n_q;
  assign idx_a = CNT_W'(rnd[7:0]) % n_div;
  assign idx_b_raw = CNT_W'(rnd[15:8]) % n_div;
  assign idx_b = (idx_b_raw != idx_a) ? idx_b_raw :
                 ((idx_b_raw + ONE == n_div) ? '0 : idx_b_raw + ONE);
  assign rnd_type = (rnd[GW +: TYPE_W] == '1) ? TYPE_W'(1) : rnd[GW +: TYPE_W];
  assign mut_word = {syn_g[idx_a[AW-1:0]][LINE_W-1:0],
                     syn_g[idx_a[AW-1:0]][2*LINE_W-1:LINE_W],
                     syn_g[idx_a[AW-1:0]][GW-1:2*LINE_W]};

  assign syn_rgate = syn_g[syn_raddr];
  assign syn_rtype = syn_t[syn_raddr];
  assign nbr_rgate = nbr_g[nbr_raddr];
  assign nbr_rtype = nbr_t[nbr_raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op_q <= '0;
      n_q <= '0;
      syn_ptr <= '0;
      nbr_ptr <= '0;
      rnd <= SEED;
      done <= 1'b0;
      syn_g <= '0;
      syn_t <= '0;
      nbr_g <= '0;
      nbr_t <= '0;
    end else begin
      rnd <= {rnd[14:0], rnd[15] ^ rnd[13] ^ rnd[12] ^ rnd[10]};
      done <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          op_q <= cmd_op;
          n_q <= n_in;
          syn_ptr <= '0;
          nbr_ptr <= '0;
          if (n_in == '0 || cmd_op == 2'd3) done <= 1'b1;
          else if (cmd_op == 2'd0) st <= S_FILL;
          else st <= S_COPY;
        end
        S_FILL: begin
          syn_g[syn_ptr[AW-1:0]] <= rnd[GW-1:0];
          syn_t[syn_ptr[AW-1:0]] <= rnd_type;
          syn_ptr <= syn_ptr + ONE;
          if (syn_ptr == n_q - ONE) begin
            st <= S_IDLE;
            done <= 1'b1;
          end
        end
        S_COPY: begin
          nbr_g[nbr_ptr[AW-1:0]] <= syn_g[syn_ptr[AW-1:0]];
          nbr_t[nbr_ptr[AW-1:0]] <= syn_t[syn_ptr[AW-1:0]];
          syn_ptr <= syn_ptr + ONE;
          nbr_ptr <= nbr_ptr + ONE;
          if (nbr_ptr == LAST) st <= S_EDIT;
        end
        S_EDIT: begin
          if (op_q == 2'd1) begin
            nbr_g[idx_a[AW-1:0]] <= syn_g[idx_b[AW-1:0]];
            nbr_t[idx_a[AW-1:0]] <= syn_t[idx_b[AW-1:0]];
            nbr_g[idx_b[AW-1:0]] <= syn_g[idx_a[AW-1:0]];
            nbr_t[idx_b[AW-1:0]] <= syn_t[idx_a[AW-1:0]];
          end else begin
            nbr_g[idx_a[AW-1:0]] <= mut_word;
          end
          st <= S_IDLE;
          done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module revgate_nbr_gen_chk #(
  parameter int GATES = 8,
  parameter int GW = 9,
  parameter int CNT_W = 8,
  parameter int LIMIT = 29
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic                  done,
  input logic [1:0]            st,
  input logic [CNT_W-1:0]      n_q,
  input logic [CNT_W-1:0]      syn_ptr,
  input logic [CNT_W-1:0]      idx_a,
  input logic [CNT_W-1:0]      idx_b,
  input logic [GATES*GW-1:0]   syn_flat,
  input logic [GATES*GW-1:0]   nbr_flat
);
  logic [7:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else busy_cnt <= (st == 2'd0) ? 8'd0 : busy_cnt + 8'd1;
  end

  // R10
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) busy_cnt <= 8'(LIMIT));
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> st == 2'd0);
  // R3
  fill_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n) (st == 2'd1) |-> syn_ptr < n_q);
  // R4
  syn_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 || st == 2'd3) |=> $stable(syn_flat));
  // R7
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3) |-> (idx_a < n_q && idx_b < n_q && (n_q == 1 || idx_a != idx_b)));
  // R8
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && !cmd_valid) |=> ($stable(syn_flat) && $stable(nbr_flat)));
endmodule

bind revgate_nbr_gen revgate_nbr_gen_chk #(.GATES(GATES), .GW(3*LINE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .done(done), .st(st), .n_q(n_q),
  .syn_ptr(syn_ptr), .idx_a(idx_a), .idx_b(idx_b), .syn_flat(syn_g), .nbr_flat(nbr_g)
);

// File: tb/revgate_nbr_gen_bench.sv
`timescale 1ns/100ps
module revgate_nbr_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] gate_count = 8'd0;
  logic done;
  logic [2:0] syn_raddr = 3'd0, nbr_raddr = 3'd0;
  logic [8:0] syn_rgate, nbr_rgate;
  logic [1:0] syn_rtype, nbr_rtype;

  int checks = 0;
  int failures = 0;
  logic [15:0] m_lfsr;
  int exp_sg[8], exp_st[8], exp_ng[8], exp_nt[8];

  always #2 clk = ~clk;

  revgate_nbr_gen u_revgate_nbr_gen (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .gate_count(gate_count), .done(done),
    .syn_raddr(syn_raddr), .syn_rgate(syn_rgate), .syn_rtype(syn_rtype),
    .nbr_raddr(nbr_raddr), .nbr_rgate(nbr_rgate), .nbr_rtype(nbr_rtype)
  );

  function automatic logic [15:0] nx(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) m_lfsr <= 16'hACE1;
    else m_lfsr <= nx(m_lfsr);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      syn_raddr = 3'(i);
      nbr_raddr = 3'(i);
      #1;
      chk(int'(syn_rgate) == exp_sg[i], req, $sformatf("syn gate %0d", i), int'(syn_rgate), exp_sg[i]);
      chk(int'(syn_rtype) == exp_st[i], req, $sformatf("syn type %0d", i), int'(syn_rtype), exp_st[i]);
      chk(int'(nbr_rgate) == exp_ng[i], req, $sformatf("nbr gate %0d", i), int'(nbr_rgate), exp_ng[i]);
      chk(int'(nbr_rtype) == exp_nt[i], req, $sformatf("nbr type %0d", i), int'(nbr_rtype), exp_nt[i]);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [7:0] cnt, input bit poke, input string req);
    int n, lat, a, b, tg, tt;
    logic [15:0] s;
    n = (cnt > 8) ? 8 : int'(cnt);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = op;
    gate_count = cnt;
    s = m_lfsr;
    if (n == 0 || op == 2'd3) lat = 0;
    else if (op == 2'd0) begin
      lat = n;
      for (int k = 0; k < n; k++) begin
        s = nx(s);
        exp_sg[k] = int'(s[8:0]);
        exp_st[k] = (s[10:9] == 2'd3) ? 1 : int'(s[10:9]);
      end
    end else begin
      lat = 9;
      for (int k = 0; k < 8; k++) begin
        exp_ng[k] = exp_sg[k];
        exp_nt[k] = exp_st[k];
      end
      for (int k = 0; k < 9; k++) s = nx(s);
      a = int'(s[7:0]) % n;
      b = int'(s[15:8]) % n;
      if (b == a) b = (b + 1) % n;
      if (op == 2'd1) begin
        tg = exp_ng[a]; tt = exp_nt[a];
        exp_ng[a] = exp_ng[b]; exp_nt[a] = exp_nt[b];
        exp_ng[b] = tg; exp_nt[b] = tt;
      end else begin
        tg = exp_sg[a];
        exp_ng[a] = ((tg & 7) << 6) | (tg & 8'h38) | ((tg >> 6) & 7);
      end
    end
    for (int c = 0; c <= lat + 2; c++) begin
      @(negedge clk);
      cmd_valid = (poke && c == 2) ? 1'b1 : 1'b0;
      cmd_op = (poke && c == 2) ? 2'd0 : op;
      #1;
      chk(done == (c == lat), req, $sformatf("done at cycle %0d", c), int'(done), int'(c == lat));
    end
    sweep(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      exp_sg[i] = 0; exp_st[i] = 0; exp_ng[i] = 0; exp_nt[i] = 0;
    end
    #1;
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    sweep("R1");
    run_cmd(2'd2, 8'd0, 1'b0, "R8 zero count");
    run_cmd(2'd3, 8'd5, 1'b0, "R8 opcode 3");
    run_cmd(2'd0, 8'd8, 1'b0, "R2 R3 R10 fill 8");
    run_cmd(2'd0, 8'd3, 1'b0, "R3 fill 3 keeps upper");
    run_cmd(2'd1, 8'd8, 1'b0, "R4 R5 R7 crossover");
    run_cmd(2'd2, 8'd8, 1'b0, "R6 R7 mutation");
    run_cmd(2'd1, 8'd1, 1'b0, "R7 crossover n=1");
    run_cmd(2'd0, 8'd200, 1'b0, "R9 clamp fill");
    run_cmd(2'd1, 8'd2, 1'b1, "R11 R7 crossover n=2 with busy strobe");
    run_cmd(2'd2, 8'd5, 1'b0, "R6 mutation n=5");
    run_cmd(2'd2, 8'd1, 1'b1, "R11 R10 mutation with busy strobe");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule